// File: doc/BRIEF.md
# Buffer Pool Occupancy and Pause Manager

This block keeps the books for a set of buffer pools in a small multi-port switch. Each arriving frame is offered on an enqueue stream with its ingress port, a 3-bit internal priority and a size in buffer units. A per-port table turns the priority into a pool index. The block admits the frame when the pool has room below its ceiling and refuses it otherwise. Accepted frames add to the pool's occupancy counter, and dequeue reports taken from the free inputs subtract from it. A free that is larger than the counter clamps it at zero and records a sticky underflow.

Each pool carries a pause state with two levels. The state turns on when occupancy reaches the upper level and turns off only once occupancy has fallen to the lower level. A per-pool port mask routes that state onto a per-port pause-request vector, which a MAC can use to send pause frames. Pause is also gated by a per-pool enable. Configuration and readback go through a plain register port with separate write and read addresses. Reads are combinational.

The enqueue stream uses valid/ready. `enq_ready` is held high, so the block never back-pressures, and a frame is taken in every cycle in which `enq_valid` is high. The verdict comes back one cycle later on `res_valid`/`res_accept`/`res_pool`. That result has no ready and cannot be stalled. The free inputs are a plain valid strobe with no handshake.

Top module: `bpool_fc_mgr`

## Requirements
- R1: After reset, every occupancy counter, underflow flag and pause output is zero and `res_valid` is low. Every pool ceiling is 1024 and flow control is off on every pool. Port p maps priorities 0..3 to pool 2p and priorities 4..7 to pool 2p+1.
- R2: Each port has a 64-bit mapping word.
  - Priority i uses byte [8i+7:8i] of that word, and the pool index is the low 3 bits of that byte.
  - Bits 31:0 are written and read at address 0x10+2p, and bits 63:32 at 0x11+2p.
- R3: `enq_ready` is always 1. A frame offered in cycle n produces `res_valid`=1 in cycle n+1. In that cycle `res_pool` is the mapped pool and `res_accept` is the verdict.
- R4: A frame is accepted only when the pool's occupancy before the edge plus `enq_units` is at most the pool's ceiling; equality is accepted. An accepted frame adds `enq_units` to the counter. A refused frame leaves every counter unchanged.
- R5: A free (`free_valid`, `free_pool`, `free_units`) subtracts its units. An accepted enqueue and a free in the same cycle, even on the same pool, net into one update. The admission test does not count that free.
- R6: If a free exceeds the pool's occupancy (including any same-cycle addition), the counter becomes 0. The pool's underflow flag is then set, and it stays set until reset.
- R7: The pause state is re-evaluated only in cycles with an accepted enqueue or a free on that pool, and only while the pool's flow control is enabled. The new occupancy sets it when it is at or above the on level. Otherwise the new occupancy clears it when it is at or below the off level, and leaves it unchanged in between. A threshold write by itself never changes the pause state.
- R8: Writing the control register with bit 0 = 0 clears that pool's on level, off level and port mask to zero. The pool's pause state is then 0 from the following cycle for as long as flow control stays disabled.
- R9: `pause_o[p]` is the OR, over all pools, of the pool's pause state ANDed with bit p of that pool's port mask. The port mask is held in control-register bits 8+NPORT-1:8.
- R10: Register map for pool k:
  - 0x20+4k is the ceiling, 0x21+4k the on level and 0x22+4k the off level, each in bits 15:0.
  - 0x23+4k is the control register, with the enable at bit 0 and the mask at bits 11:8.
  - 0x40+k is a read-only view: occupancy in bits 15:0 and the underflow flag in bit 16.
  - 0x00 is a read-only capability register with the pool count (8) in bits 7:0.
  - Writes to 0x00 and to 0x40..0x47 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Frame offered for admission |
| enq_ready | output | 1 | Always 1, no back-pressure |
| enq_port | input | 2 | Ingress port of the frame |
| enq_prio | input | 3 | Internal priority of the frame |
| enq_units | input | 16 | Buffer units the frame needs |
| res_valid | output | 1 | Admission result valid, one cycle after the offer |
| res_accept | output | 1 | 1 = frame admitted, 0 = refused |
| res_pool | output | 3 | Pool the frame was mapped to |
| free_valid | input | 1 | Dequeue release strobe |
| free_pool | input | 3 | Pool being released |
| free_units | input | 16 | Units released |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 8 | Register read address |
| cfg_rdata | output | 32 | Register read data (combinational) |
| pause_o | output | 4 | Per-port pause request |

## Verification
Admission of a frame and a release on the same pool can land on the same clock edge. In that case they must net into one counter value, and the admission test must still use the occupancy that was present before the edge. The bench provokes this with a directed cycle that offers a frame and frees units on one pool together. It also provokes it with a random phase in which enqueue and free strobes overlap often. Every cycle is judged by the bench's pool model, which checks the verdict, the mapped pool and the pause vector. The model also checks the occupancy and underflow flag read back through the register port.

// File: rtl/bpool_pkg.sv
package bpool_pkg;
  localparam int CNT_W = 16;
  typedef enum logic [1:0] {
    REG_MAX  = 2'd0,
    REG_ON   = 2'd1,
    REG_OFF  = 2'd2,
    REG_CTRL = 2'd3
  } pool_reg_e;
endpackage

// File: rtl/bpool_map.sv
module bpool_map #(
  parameter int NPORT = 4,
  parameter int NPRIO = 8,
  parameter int NPOOL = 8,
  localparam int PTW = $clog2(NPORT),
  localparam int QW  = $clog2(NPRIO),
  localparam int PW  = $clog2(NPOOL),
  localparam int PPP = NPOOL / NPORT,
  localparam int PG  = NPRIO / PPP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [PTW-1:0] wr_port,
  input  logic           wr_hi,
  input  logic [31:0]    wdata,
  input  logic [PTW-1:0] lk_port,
  input  logic [QW-1:0]  lk_prio,
  output logic [PW-1:0]  lk_pool,
  input  logic [PTW-1:0] rd_port,
  input  logic           rd_hi,
  output logic [31:0]    rd_data
);
  logic [7:0] map_q [NPORT][NPRIO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++)
        for (int i = 0; i < NPRIO; i++)
          map_q[p][i] <= 8'(p * PPP + i / PG);
    end else if (we) begin
      for (int i = 0; i < NPRIO; i++)
        if ((i / 4) == int'(wr_hi))
          map_q[wr_port][i] <= wdata[8*(i%4) +: 8];
    end
  end

  assign lk_pool = map_q[lk_port][lk_prio][PW-1:0];

  always_comb begin
    for (int b = 0; b < 4; b++)
      rd_data[8*b +: 8] = map_q[rd_port][QW'(4 * int'(rd_hi) + b)];
  end
endmodule

// File: rtl/bpool_pool.sv
module bpool_pool
  import bpool_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int CW      = CNT_W,
  parameter int DEF_MAX = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CW-1:0]    add_units,
  input  logic             sub_en,
  input  logic [CW-1:0]    sub_units,
  input  logic             cfg_we,
  input  pool_reg_e        cfg_reg,
  input  logic [CW-1:0]    cfg_val,
  input  logic             cfg_en,
  input  logic [NPORT-1:0] cfg_mask,
  output logic             fits_o,
  output logic [CW-1:0]    occ_o,
  output logic             uflow_o,
  output logic             pause_o,
  output logic [CW-1:0]    max_o,
  output logic [CW-1:0]    on_o,
  output logic [CW-1:0]    off_o,
  output logic             en_o,
  output logic [NPORT-1:0] mask_o
);
  logic [CW:0]   sum;
  logic [CW-1:0] nxt;
  logic          under;
  logic          evt;

  assign fits_o = ({1'b0, occ_o} + {1'b0, add_units}) <= {1'b0, max_o};
  assign evt    = add_en | sub_en;

  always_comb begin
    sum   = {1'b0, occ_o} + (add_en ? {1'b0, add_units} : '0);
    under = sub_en && ({1'b0, sub_units} > sum);
    if (under)       nxt = '0;
    else if (sub_en) nxt = CW'(sum - {1'b0, sub_units});
    else             nxt = CW'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_o   <= '0;
      uflow_o <= 1'b0;
      pause_o <= 1'b0;
    end else begin
      if (evt) occ_o <= nxt;
      if (under) uflow_o <= 1'b1;
      if (!en_o) pause_o <= 1'b0;
      else if (evt) begin
        if (nxt >= on_o)       pause_o <= 1'b1;
        else if (nxt <= off_o) pause_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_o  <= CW'(DEF_MAX);
      on_o   <= '0;
      off_o  <= '0;
      en_o   <= 1'b0;
      mask_o <= '0;
    end else if (cfg_we) begin
      unique case (cfg_reg)
        REG_MAX: max_o <= cfg_val;
        REG_ON:  on_o  <= cfg_val;
        REG_OFF: off_o <= cfg_val;
        REG_CTRL: begin
          en_o <= cfg_en;
          if (cfg_en) mask_o <= cfg_mask;
          else begin
            mask_o <= '0;
            on_o   <= '0;
            off_o  <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bpool_pause_or.sv
module bpool_pause_or #(
  parameter int NPORT = 4,
  parameter int NPOOL = 8
) (
  input  logic [NPOOL-1:0]            pool_pause,
  input  logic [NPOOL-1:0][NPORT-1:0] pool_mask,
  output logic [NPORT-1:0]            port_pause
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      port_pause[p] = 1'b0;
      for (int k = 0; k < NPOOL; k++)
        port_pause[p] = port_pause[p] | (pool_pause[k] & pool_mask[k][p]);
    end
  end
endmodule

// File: rtl/bpool_fc_mgr.sv
module bpool_fc_mgr
  import bpool_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int NPRIO   = 8,
  parameter int NPOOL   = 8,
  parameter int CW      = CNT_W,
  parameter int DEF_MAX = 1024,
  localparam int PTW = $clog2(NPORT),
  localparam int QW  = $clog2(NPRIO),
  localparam int PW  = $clog2(NPOOL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [PTW-1:0]   enq_port,
  input  logic [QW-1:0]    enq_prio,
  input  logic [CW-1:0]    enq_units,
  output logic             res_valid,
  output logic             res_accept,
  output logic [PW-1:0]    res_pool,
  input  logic             free_valid,
  input  logic [PW-1:0]    free_pool,
  input  logic [CW-1:0]    free_units,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_waddr,
  input  logic [31:0]      cfg_wdata,
  input  logic [7:0]       cfg_raddr,
  output logic [31:0]      cfg_rdata,
  output logic [NPORT-1:0] pause_o
);
  logic [PW-1:0]                pool_sel;
  logic                         accept;
  logic                         map_we, pool_we;
  logic [31:0]                  map_rd;
  logic [NPOOL-1:0]             fits_w, uflow_w, pause_w, en_w;
  logic [NPOOL-1:0]             add_en, sub_en;
  logic [NPOOL-1:0][CW-1:0]     occ_w, max_w, on_w, off_w;
  logic [NPOOL-1:0][NPORT-1:0]  mask_w;
  logic [PW-1:0]                rpool, opool;

  assign enq_ready = 1'b1;
  assign map_we  = cfg_we && (cfg_waddr[7:4] == 4'h1) && !cfg_waddr[3];
  assign pool_we = cfg_we && (cfg_waddr[7:5] == 3'b001);

  bpool_map #(.NPORT(NPORT), .NPRIO(NPRIO), .NPOOL(NPOOL)) u_map (
    .clk(clk), .rst_n(rst_n),
    .we(map_we), .wr_port(cfg_waddr[PTW:1]), .wr_hi(cfg_waddr[0]), .wdata(cfg_wdata),
    .lk_port(enq_port), .lk_prio(enq_prio), .lk_pool(pool_sel),
    .rd_port(cfg_raddr[PTW:1]), .rd_hi(cfg_raddr[0]), .rd_data(map_rd)
  );

  assign accept = enq_valid && fits_w[pool_sel];

  for (genvar k = 0; k < NPOOL; k++) begin : g_pool
    assign add_en[k] = accept && (pool_sel == PW'(k));
    assign sub_en[k] = free_valid && (free_pool == PW'(k));
    bpool_pool #(.NPORT(NPORT), .CW(CW), .DEF_MAX(DEF_MAX)) u_pool (
      .clk(clk), .rst_n(rst_n),
      .add_en(add_en[k]), .add_units(enq_units),
      .sub_en(sub_en[k]), .sub_units(free_units),
      .cfg_we(pool_we && (cfg_waddr[PW+1:2] == PW'(k))),
      .cfg_reg(pool_reg_e'(cfg_waddr[1:0])),
      .cfg_val(cfg_wdata[CW-1:0]), .cfg_en(cfg_wdata[0]),
      .cfg_mask(cfg_wdata[8 +: NPORT]),
      .fits_o(fits_w[k]), .occ_o(occ_w[k]), .uflow_o(uflow_w[k]), .pause_o(pause_w[k]),
      .max_o(max_w[k]), .on_o(on_w[k]), .off_o(off_w[k]), .en_o(en_w[k]), .mask_o(mask_w[k])
    );
  end

  bpool_pause_or #(.NPORT(NPORT), .NPOOL(NPOOL)) u_or (
    .pool_pause(pause_w), .pool_mask(mask_w), .port_pause(pause_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_pool   <= '0;
    end else begin
      res_valid  <= enq_valid;
      res_accept <= accept;
      res_pool   <= pool_sel;
    end
  end

  assign rpool = cfg_raddr[PW+1:2];
  assign opool = cfg_raddr[PW-1:0];

  always_comb begin
    cfg_rdata = '0;
    if (cfg_raddr == 8'h00) begin
      cfg_rdata = 32'(NPOOL);
    end else if (cfg_raddr[7:4] == 4'h1 && !cfg_raddr[3]) begin
      cfg_rdata = map_rd;
    end else if (cfg_raddr[7:5] == 3'b001) begin
      unique case (cfg_raddr[1:0])
        2'd0: cfg_rdata = 32'(max_w[rpool]);
        2'd1: cfg_rdata = 32'(on_w[rpool]);
        2'd2: cfg_rdata = 32'(off_w[rpool]);
        2'd3: cfg_rdata = (32'(mask_w[rpool]) << 8) | 32'(en_w[rpool]);
      endcase
    end else if (cfg_raddr[7:4] == 4'h4 && !cfg_raddr[3]) begin
      cfg_rdata = (32'(uflow_w[opool]) << 16) | 32'(occ_w[opool]);
    end
  end
endmodule

// File: rtl/bpool_fc_chk.sv
module bpool_fc_chk #(
  parameter int NPORT = 4,
  parameter int NPOOL = 8,
  parameter int CW    = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPOOL-1:0][CW-1:0] occ,
  input logic [NPOOL-1:0][CW-1:0] max_th,
  input logic [NPOOL-1:0][CW-1:0] on_th,
  input logic [NPOOL-1:0][CW-1:0] off_th,
  input logic [NPOOL-1:0]         fc_en,
  input logic [NPOOL-1:0]         uflow,
  input logic [NPOOL-1:0]         pool_pause,
  input logic [NPORT-1:0]         pause_o
);
  for (genvar k = 0; k < NPOOL; k++) begin : g_chk
    // R4: growth never lands above the ceiling in force before the edge
    p_grow_within_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[k] > $past(occ[k])) |-> (occ[k] <= $past(max_th[k])));
    // R6: underflow flag is sticky
    p_uflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(uflow[k]) |-> uflow[k]);
    // R7: pause rises only at or above the on level
    p_rise_at_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pool_pause[k]) |-> (occ[k] >= $past(on_th[k])));
    // R7: pause falls while enabled only at or below the off level
    p_fall_at_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pool_pause[k]) && $past(fc_en[k])) |-> (occ[k] <= $past(off_th[k])));
    // R8: disabled pool holds no pause
    p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fc_en[k]) |-> !pool_pause[k]);
  end
  // R9: a port pause needs some pool in pause
  p_port_needs_pool_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pause_o) |-> (|pool_pause));
endmodule

bind bpool_fc_mgr bpool_fc_chk #(.NPORT(NPORT), .NPOOL(NPOOL), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ_w), .max_th(max_w), .on_th(on_w), .off_th(off_w),
  .fc_en(en_w), .uflow(uflow_w), .pool_pause(pause_w), .pause_o(pause_o)
);

// File: tb/tb_bpool_fc_mgr.sv
module tb_bpool_fc_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [1:0]  enq_port = '0;
  logic [2:0]  enq_prio = '0;
  logic [15:0] enq_units = '0;
  logic        res_valid, res_accept;
  logic [2:0]  res_pool;
  logic        free_valid = 1'b0;
  logic [2:0]  free_pool = '0;
  logic [15:0] free_units = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pause_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_occ[8], m_uf[8], m_pause[8], m_max[8], m_on[8], m_off[8], m_en[8], m_mask[8];
  int m_map[4][8];

  always #5 clk = ~clk;

  bpool_fc_mgr dut (.*);

  function automatic int lookup(int p, int q);
    return m_map[p][q] & 7;
  endfunction

  function automatic int exp_pause();
    int v = 0;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++)
        if (m_pause[k] != 0 && ((m_mask[k] >> p) & 1) != 0) v |= (1 << p);
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 8; k++) begin
      m_occ[k] = 0; m_uf[k] = 0; m_pause[k] = 0; m_max[k] = 1024;
      m_on[k] = 0; m_off[k] = 0; m_en[k] = 0; m_mask[k] = 0;
    end
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 8; q++) m_map[p][q] = 2 * p + q / 4;
  endtask

  // one cycle of traffic; begins and ends just after a falling edge
  task automatic step(string tag, bit ev, int ep, int eq, int eu, bit fv, int fp, int fu);
    int pool, acc, t;
    enq_valid = ev; enq_port = 2'(ep); enq_prio = 3'(eq); enq_units = 16'(eu);
    free_valid = fv; free_pool = 3'(fp); free_units = 16'(fu);
    pool = lookup(ep, eq);
    acc = (ev && (m_occ[pool] + eu <= m_max[pool])) ? 1 : 0;
    for (int k = 0; k < 8; k++) begin
      bit evk = 0;
      t = m_occ[k];
      if (acc != 0 && k == pool) begin t += eu; evk = 1; end
      if (fv && k == fp) begin
        evk = 1;
        if (fu > t) begin t = 0; m_uf[k] = 1; end else t -= fu;
      end
      if (m_en[k] == 0) m_pause[k] = 0;
      else if (evk) begin
        if (t >= m_on[k]) m_pause[k] = 1;
        else if (t <= m_off[k]) m_pause[k] = 0;
      end
      m_occ[k] = t;
    end
    @(posedge clk); @(negedge clk);
    enq_valid = 0; free_valid = 0;
    check({tag, " R3 res_valid"}, int'(res_valid), int'(ev));
    if (ev) begin
      check({tag, " R3/R2 res_pool"}, int'(res_pool), pool);
      check({tag, " R4 res_accept"}, int'(res_accept), acc);
    end
    check({tag, " R7/R9 pause_o"}, int'(pause_o), exp_pause());
  endtask

  task automatic cfg_write(int a, int d);
    cfg_we = 1; cfg_waddr = 8'(a); cfg_wdata = 32'(d);
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    if (a >= 8'h10 && a <= 8'h17) begin
      for (int q = 0; q < 8; q++)
        if (q / 4 == (a & 1)) m_map[(a >> 1) & 3][q] = (d >> (8 * (q % 4))) & 8'hFF;
    end else if (a >= 8'h20 && a <= 8'h3F) begin
      int k = (a >> 2) & 7;
      case (a & 3)
        0: m_max[k] = d & 16'hFFFF;
        1: m_on[k]  = d & 16'hFFFF;
        2: m_off[k] = d & 16'hFFFF;
        default: begin
          m_en[k] = d & 1;
          if (m_en[k] != 0) m_mask[k] = (d >> 8) & 4'hF;
          else begin m_mask[k] = 0; m_on[k] = 0; m_off[k] = 0; end
        end
      endcase
    end
  endtask

  task automatic rd_check(string tag, int a, int exp);
    cfg_raddr = 8'(a);
    #1;
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic check_occ_all(string tag);
    for (int k = 0; k < 8; k++)
      rd_check(tag, 8'h40 + k, (m_uf[k] << 16) | m_occ[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 pause_o", int'(pause_o), 0);
    check("R3 enq_ready", int'(enq_ready), 1);
    check_occ_all("R1 occupancy");
    rd_check("R1 map low port1", 8'h12, 32'h02020202);
    rd_check("R1 map high port1", 8'h13, 32'h03030303);
    rd_check("R1 ceiling pool0", 8'h20, 1024);
    rd_check("R10 capability", 8'h00, 8);

    // R10 writes to read-only addresses are ignored
    cfg_write(8'h00, 32'hFF);
    rd_check("R10 cap after write", 8'h00, 8);
    cfg_write(8'h41, 5);
    rd_check("R10 occ after write", 8'h41, 0);

    // R2 map write and use
    cfg_write(8'h11, 32'h07060504);
    rd_check("R2 map readback", 8'h11, 32'h07060504);
    step("R2 prio5", 1, 0, 5, 3, 0, 0, 0);
    rd_check("R2 occ pool5", 8'h45, 3);

    // R4 ceiling boundary
    cfg_write(8'h20, 10);
    step("R4 equal ceiling", 1, 0, 0, 10, 0, 0, 0);
    step("R4 one over", 1, 0, 0, 1, 0, 0, 0);
    rd_check("R4 occ unchanged", 8'h40, 10);

    // R5 same-cycle netting
    step("R5 free", 0, 0, 0, 0, 1, 0, 5);
    step("R5 enq+free", 1, 0, 1, 3, 1, 0, 2);
    rd_check("R5 net occ", 8'h40, 6);
    step("R5 admit ignores free", 1, 0, 2, 5, 1, 0, 4);
    rd_check("R5 occ after refused", 8'h40, 2);

    // R6 underflow
    step("R6 free empty", 0, 0, 0, 0, 1, 2, 1);
    rd_check("R6 uflow", 8'h42, 32'h10000);
    step("R6 alloc after", 1, 1, 0, 4, 0, 0, 0);
    rd_check("R6 sticky", 8'h42, 32'h10004);

    // R7 hysteresis on pool 3 (port1 prio4..7), mask port1
    cfg_write(8'h2C, 100);
    cfg_write(8'h2D, 20);
    cfg_write(8'h2E, 8);
    cfg_write(8'h2F, 32'h201);
    step("R7 below on", 1, 1, 4, 19, 0, 0, 0);
    step("R7 reach on", 1, 1, 4, 1, 0, 0, 0);
    check("R7 pause port1", int'(pause_o), 2);
    step("R7 hold", 0, 0, 0, 0, 1, 3, 5);
    cfg_write(8'h2E, 16);
    step("R7 write alone holds", 0, 0, 0, 0, 0, 0, 0);
    check("R7 still paused", int'(pause_o), 2);
    step("R7 fall to off", 0, 0, 0, 0, 1, 3, 1);
    check("R7 cleared", int'(pause_o), 0);

    // R9 mask onto another port
    cfg_write(8'h2F, 32'h801);
    step("R9 re-arm", 1, 1, 5, 10, 0, 0, 0);
    check("R9 pause port3", int'(pause_o), 8);

    // R8 disable
    cfg_write(8'h2F, 0);
    rd_check("R8 on cleared", 8'h2D, 0);
    rd_check("R8 off cleared", 8'h2E, 0);
    rd_check("R8 ctrl cleared", 8'h2F, 0);
    step("R8 idle", 0, 0, 0, 0, 0, 0, 0);
    check("R8 no pause", int'(pause_o), 0);
    step("R8 alloc disabled", 1, 1, 6, 30, 0, 0, 0);
    check("R8 still none", int'(pause_o), 0);

    // random phase
    for (int k = 0; k < 8; k++) begin
      cfg_write(8'h20 + 4 * k, 60 + $urandom_range(0, 100));
      cfg_write(8'h21 + 4 * k, 40);
      cfg_write(8'h22 + 4 * k, 15);
      cfg_write(8'h23 + 4 * k, 1 | ((1 << ((k / 2 + (k % 2) * $urandom_range(0, 1)) % 4)) << 8));
    end
    for (int n = 0; n < 3000; n++) begin
      bit ev = ($urandom_range(0, 9) < 6);
      bit fv = ($urandom_range(0, 9) < 5);
      step("R5 random", ev, $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(1, 12),
           fv, $urandom_range(0, 7), $urandom_range(1, 12));
      if (n % 100 == 99) check_occ_all("R4/R5/R6 random occ");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule